// File: doc/BRIEF.md
# BIP-8 Link Error Monitor

This block supervises a set of byte-wide, frame-structured serial links. Each channel has a transmit half and a receive half. The transmit half takes an outgoing byte stream and keeps a running even-parity XOR of every byte it sends. In the following frame, it writes that parity byte over the byte at a fixed parity slot. The receive half computes the same running parity over each incoming frame. It then compares the result with the parity slot of the next frame and counts every bit that differs.

A frame begins with the byte that carries the start-of-frame strobe. That byte is index 0. Only bytes qualified by the valid strobe count toward the index and the parity. The error count for each channel saturates and has a sticky overflow bit. Each channel also has a sticky interrupt flag. Software reads the count and then clears it with a read-and-clear strobe. The interrupt flag has its own clear strobe. All channels are generated from one parameter and run fully independently.

Top module: `bip8_link_monitor`

## Requirements
- R1: Every transmit byte with valid high appears on the transmit output exactly one cycle later, together with its start strobe. Every byte except the parity slot keeps its value.
- R2: The parity slot is byte index B1_POS (default 2), counted with the start byte as index 0. From the second frame after reset onward, this slot is replaced on the output by the XOR of all output bytes of the previous frame, including that frame's own slot byte. In the first frame, the slot passes through unchanged.
- R3: The receive half does not check the first frame after reset. From the second frame on, it compares the parity slot byte with the XOR of all received bytes of the previous frame.
- R4: A parity mismatch adds the number of differing bits (0 to 8) to the channel's 7-bit error count. The new count is visible the cycle after the slot byte.
- R5: If an addition would take the count above 127, the count stays at 127 and the overflow bit is set. Both hold until a clear.
- R6: A read-and-clear strobe zeroes the count and the overflow bit. If a mismatch arrives in the same cycle, it is added to zero rather than lost.
- R7: Any nonzero mismatch sets the channel's interrupt flag. The flag stays set until its clear strobe. If a set and a clear fall in the same cycle, the set wins.
- R8: Each channel's framing, parity, count, overflow and interrupt depend only on that channel's inputs.
- R9: A byte with valid low does not advance the byte index and does not enter the parity. The transmit output valid is low in the cycle after it.
- R10: After reset, all counts, overflow bits, interrupt flags and transmit output valids are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_in_data | input | NCH*8 | Transmit bytes, channel c in bits [8c+7:8c] |
| tx_in_sof | input | NCH | Transmit start-of-frame strobe |
| tx_in_valid | input | NCH | Transmit byte valid |
| tx_out_data | output | NCH*8 | Transmit bytes with parity inserted |
| tx_out_sof | output | NCH | Delayed start-of-frame strobe |
| tx_out_valid | output | NCH | Delayed byte valid |
| rx_data | input | NCH*8 | Received bytes |
| rx_sof | input | NCH | Receive start-of-frame strobe |
| rx_valid | input | NCH | Receive byte valid |
| clr_cnt | input | NCH | Read-and-clear strobe for count and overflow |
| clr_irq | input | NCH | Clear strobe for interrupt flag |
| err_cnt | output | NCH*7 | Saturating bit-error count per channel |
| err_ovf | output | NCH | Sticky overflow bit per channel |
| irq | output | NCH | Sticky interrupt flag per channel |

## Verification
Two pairs of events can land in the same cycle: a read-and-clear strobe with a mismatching parity slot, and an interrupt clear with a new mismatch. Random clear strobes run against random slot corruption, so both pairs occur many times. A directed phase also raises the count clear exactly on every slot byte of a channel whose slot is fully inverted. The bench judges each cycle against its own model. In that model, the cleared count restarts at the new mismatch weight and the overflow bit stays low, and the interrupt stays set when set and clear coincide.

// File: rtl/bip8_mon_pkg.sv
package bip8_mon_pkg;
    localparam int BYTE_W = 8;
    localparam int ERR_W  = 4;

    function automatic logic [ERR_W-1:0] bit_weight(input logic [BYTE_W-1:0] v);
        logic [ERR_W-1:0] n;
        n = '0;
        for (int i = 0; i < BYTE_W; i++) begin
            n = n + {{(ERR_W-1){1'b0}}, v[i]};
        end
        return n;
    endfunction
endpackage

// File: rtl/bip8_frame_pos.sv
module bip8_frame_pos #(
    parameter int IDX_W  = 4,
    parameter int B1_POS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic valid,
    input  logic sof,
    output logic at_b1
);
    localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};
    localparam logic [IDX_W-1:0] SLOT    = IDX_W'(B1_POS);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } pos_t;

    pos_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (valid) begin
            if (sof) begin
                s_d.idx = IDX_W'(1);
            end else if (s_q.idx != IDX_MAX) begin
                s_d.idx = s_q.idx + IDX_W'(1);
            end
        end
        at_b1 = valid && !sof && (s_q.idx == SLOT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.idx <= IDX_MAX;
        end else begin
            s_q <= s_d;
        end
    end

    // R9: a gap byte leaves the slot decision unchanged
    p_gap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> (s_q.idx == $past(s_q.idx)));
endmodule

// File: rtl/bip8_tx_inserter.sv
module bip8_tx_inserter
    import bip8_mon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_sof,
    input  logic              in_valid,
    input  logic              at_b1,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_sof,
    output logic              out_valid
);
    typedef struct packed {
        logic [BYTE_W-1:0] acc;
        logic [BYTE_W-1:0] exp;
        logic              exp_vld;
        logic              started;
        logic [BYTE_W-1:0] od;
        logic              os;
        logic              ov;
    } tx_t;

    tx_t s_d, s_q;
    logic [BYTE_W-1:0] byte_out;

    always_comb begin
        s_d      = s_q;
        byte_out = (at_b1 && s_q.exp_vld) ? s_q.exp : in_data;
        if (in_valid) begin
            if (in_sof) begin
                s_d.exp     = s_q.acc;
                s_d.exp_vld = s_q.started;
                s_d.started = 1'b1;
                s_d.acc     = byte_out;
            end else begin
                s_d.acc = s_q.acc ^ byte_out;
            end
        end
        s_d.od = byte_out;
        s_d.os = in_valid && in_sof;
        s_d.ov = in_valid;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_data  = s_q.od;
    assign out_sof   = s_q.os;
    assign out_valid = s_q.ov;

    // R1: non-slot bytes leave unchanged one cycle later
    p_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !at_b1) |=> (out_valid && out_data == $past(in_data)));
    // R9: a gap in gives a gap out
    p_gap_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
endmodule

// File: rtl/bip8_rx_checker.sv
module bip8_rx_checker
    import bip8_mon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] data,
    input  logic              sof,
    input  logic              valid,
    input  logic              at_b1,
    output logic [ERR_W-1:0]  err_bits
);
    typedef struct packed {
        logic [BYTE_W-1:0] acc;
        logic [BYTE_W-1:0] exp;
        logic              exp_vld;
        logic              started;
    } rx_t;

    rx_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (valid) begin
            if (sof) begin
                s_d.exp     = s_q.acc;
                s_d.exp_vld = s_q.started;
                s_d.started = 1'b1;
                s_d.acc     = data;
            end else begin
                s_d.acc = s_q.acc ^ data;
            end
        end
        err_bits = (at_b1 && s_q.exp_vld) ? bit_weight(data ^ s_q.exp) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R3: mismatches only ever come from the parity slot
    p_err_only_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !at_b1 |-> (err_bits == '0));
    // R4: at most one weight per byte
    p_err_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err_bits <= ERR_W'(BYTE_W));
endmodule

// File: rtl/bip8_err_counter.sv
module bip8_err_counter
    import bip8_mon_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_W-1:0] err_bits,
    input  logic             clr_cnt,
    input  logic             clr_irq,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf,
    output logic             irq
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
    localparam logic [CNT_W:0]   CMAX_W = {1'b0, CMAX};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
        logic             irq;
    } ctr_t;

    ctr_t s_d, s_q;
    logic [CNT_W-1:0] base;
    logic [CNT_W:0]   sum;

    always_comb begin
        s_d  = s_q;
        base = clr_cnt ? '0 : s_q.cnt;
        sum  = {1'b0, base} + {{(CNT_W+1-ERR_W){1'b0}}, err_bits};
        if (sum > CMAX_W) begin
            s_d.cnt = CMAX;
            s_d.ovf = 1'b1;
        end else begin
            s_d.cnt = sum[CNT_W-1:0];
            s_d.ovf = clr_cnt ? 1'b0 : s_q.ovf;
        end
        s_d.irq = (err_bits != '0) || (s_q.irq && !clr_irq);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt = s_q.cnt;
    assign ovf = s_q.ovf;
    assign irq = s_q.irq;

    // R4: an unsaturated addition lands exactly
    p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_cnt && ({1'b0, cnt} + {{(CNT_W+1-ERR_W){1'b0}}, err_bits}) <= CMAX_W)
        |=> (cnt == $past(cnt) + {{(CNT_W-ERR_W){1'b0}}, $past(err_bits)}));
    // R5: saturated count and overflow hold without a clear
    p_sat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CMAX && !clr_cnt) |=> (cnt == CMAX));
    p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr_cnt) |=> ovf);
    p_ovf_at_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> (cnt == CMAX));
    // R6: clear with no new error empties the counter
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_cnt && err_bits == '0) |=> (cnt == '0 && !ovf));
    // R7: set and sticky interrupt
    p_irq_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_bits != '0) |=> irq);
    p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_irq) |=> irq);
endmodule

// File: rtl/bip8_link_monitor.sv
module bip8_link_monitor
    import bip8_mon_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CNT_W  = 7,
    parameter int IDX_W  = 4,
    parameter int B1_POS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCH*8-1:0]    tx_in_data,
    input  logic [NCH-1:0]      tx_in_sof,
    input  logic [NCH-1:0]      tx_in_valid,
    output logic [NCH*8-1:0]    tx_out_data,
    output logic [NCH-1:0]      tx_out_sof,
    output logic [NCH-1:0]      tx_out_valid,
    input  logic [NCH*8-1:0]    rx_data,
    input  logic [NCH-1:0]      rx_sof,
    input  logic [NCH-1:0]      rx_valid,
    input  logic [NCH-1:0]      clr_cnt,
    input  logic [NCH-1:0]      clr_irq,
    output logic [NCH*CNT_W-1:0] err_cnt,
    output logic [NCH-1:0]      err_ovf,
    output logic [NCH-1:0]      irq
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic             tx_b1;
        logic             rx_b1;
        logic [ERR_W-1:0] errs;

        bip8_frame_pos #(.IDX_W(IDX_W), .B1_POS(B1_POS)) u_tx_pos (
            .clk   (clk),
            .rst_n (rst_n),
            .valid (tx_in_valid[c]),
            .sof   (tx_in_sof[c]),
            .at_b1 (tx_b1)
        );

        bip8_tx_inserter u_tx (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_data   (tx_in_data[c*BYTE_W +: BYTE_W]),
            .in_sof    (tx_in_sof[c]),
            .in_valid  (tx_in_valid[c]),
            .at_b1     (tx_b1),
            .out_data  (tx_out_data[c*BYTE_W +: BYTE_W]),
            .out_sof   (tx_out_sof[c]),
            .out_valid (tx_out_valid[c])
        );

        bip8_frame_pos #(.IDX_W(IDX_W), .B1_POS(B1_POS)) u_rx_pos (
            .clk   (clk),
            .rst_n (rst_n),
            .valid (rx_valid[c]),
            .sof   (rx_sof[c]),
            .at_b1 (rx_b1)
        );

        bip8_rx_checker u_rx (
            .clk      (clk),
            .rst_n    (rst_n),
            .data     (rx_data[c*BYTE_W +: BYTE_W]),
            .sof      (rx_sof[c]),
            .valid    (rx_valid[c]),
            .at_b1    (rx_b1),
            .err_bits (errs)
        );

        bip8_err_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .err_bits (errs),
            .clr_cnt  (clr_cnt[c]),
            .clr_irq  (clr_irq[c]),
            .cnt      (err_cnt[c*CNT_W +: CNT_W]),
            .ovf      (err_ovf[c]),
            .irq      (irq[c])
        );
    end
endmodule

// File: tb/bip8_link_monitor_bench.sv
module bip8_link_monitor_bench;
    localparam int NCH = 4;
    localparam int CW = 7;
    localparam int SLOT = 2;
    localparam int IMAX = 15;
    localparam int CMAX = 127;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n;
    logic [NCH*8-1:0] tx_in_data, tx_out_data, rx_data;
    logic [NCH-1:0] tx_in_sof, tx_in_valid, tx_out_sof, tx_out_valid;
    logic [NCH-1:0] rx_sof, rx_valid, clr_cnt, clr_irq, err_ovf, irq;
    logic [NCH*CW-1:0] err_cnt;

    bip8_link_monitor u_bip8_link_monitor (
        .clk(clk), .rst_n(rst_n),
        .tx_in_data(tx_in_data), .tx_in_sof(tx_in_sof), .tx_in_valid(tx_in_valid),
        .tx_out_data(tx_out_data), .tx_out_sof(tx_out_sof), .tx_out_valid(tx_out_valid),
        .rx_data(rx_data), .rx_sof(rx_sof), .rx_valid(rx_valid),
        .clr_cnt(clr_cnt), .clr_irq(clr_irq),
        .err_cnt(err_cnt), .err_ovf(err_ovf), .irq(irq)
    );

    int n_checks = 0;
    int n_errors = 0;

    int t_idx[NCH], r_idx[NCH], flen_t[NCH], flen_r[NCH], m_cnt[NCH];
    logic [7:0] t_acc[NCH], t_exp[NCH], r_acc[NCH], r_exp[NCH], e_td[NCH];
    bit t_ev[NCH], t_st[NCH], r_ev[NCH], r_st[NCH], m_ovf[NCH], m_irq[NCH];
    bit e_tv[NCH], e_ts[NCH];
    bit idle[NCH], flip_all[NCH], clr_on_b1[NCH];
    bit no_rand_clr;

    function automatic int weight(input logic [7:0] v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += int'(v[i]);
        return n;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input int ch, input int got, input int expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s ch%0d %s got %0d expected %0d", tag, ch, what, got, expv);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin
            t_idx[c] = IMAX; r_idx[c] = IMAX; flen_t[c] = 5; flen_r[c] = 5;
            t_acc[c] = 0; t_exp[c] = 0; r_acc[c] = 0; r_exp[c] = 0; e_td[c] = 0;
            t_ev[c] = 0; t_st[c] = 0; r_ev[c] = 0; r_st[c] = 0;
            m_cnt[c] = 0; m_ovf[c] = 0; m_irq[c] = 0; e_tv[c] = 0; e_ts[c] = 0;
            idle[c] = 0; flip_all[c] = 0; clr_on_b1[c] = 0;
        end
    endtask

    task automatic compare_all();
        for (int c = 0; c < NCH; c++) begin
            chk(tx_out_valid[c] == e_tv[c], "R9", "tx_out_valid", c, tx_out_valid[c], e_tv[c]);
            if (e_tv[c]) begin
                chk(tx_out_sof[c] == e_ts[c], "R1", "tx_out_sof", c, tx_out_sof[c], e_ts[c]);
                chk(tx_out_data[c*8 +: 8] == e_td[c], "R2", "tx_out_data", c,
                    tx_out_data[c*8 +: 8], e_td[c]);
            end
            chk(err_cnt[c*CW +: CW] == m_cnt[c], "R4", "err_cnt", c, err_cnt[c*CW +: CW], m_cnt[c]);
            chk(err_ovf[c] == m_ovf[c], "R5", "err_ovf", c, err_ovf[c], m_ovf[c]);
            chk(irq[c] == m_irq[c], "R7", "irq", c, irq[c], m_irq[c]);
        end
    endtask

    // drive one cycle at the falling edge, advance the model, compare at the next falling edge
    task automatic step();
        for (int c = 0; c < NCH; c++) begin
            bit v, s, ab1, rv, rs, rb1, cl, ci;
            logic [7:0] d, od, rd;
            int e, base, sum, mode;
            v = !idle[c] && ($urandom % 5 != 0);
            s = v && (t_idx[c] >= flen_t[c]);
            if (s) flen_t[c] = 3 + int'($urandom % 8);
            d = 8'($urandom);
            ab1 = v && !s && (t_idx[c] == SLOT);
            od = (ab1 && t_ev[c]) ? t_exp[c] : d;
            e_tv[c] = v; e_ts[c] = s;
            if (v) begin
                e_td[c] = od;
                if (s) begin
                    t_exp[c] = t_acc[c]; t_ev[c] = t_st[c]; t_st[c] = 1; t_acc[c] = od; t_idx[c] = 1;
                end else begin
                    t_acc[c] ^= od;
                    if (t_idx[c] < IMAX) t_idx[c]++;
                end
            end
            tx_in_valid[c] = v; tx_in_sof[c] = s; tx_in_data[c*8 +: 8] = d;

            rv = !idle[c] && ($urandom % 5 != 0);
            rs = rv && (r_idx[c] >= flen_r[c]);
            if (rs) flen_r[c] = 3 + int'($urandom % 8);
            rb1 = rv && !rs && (r_idx[c] == SLOT);
            rd = 8'($urandom);
            if (rb1) begin
                mode = int'($urandom % 10);
                if (flip_all[c]) rd = r_exp[c] ^ 8'hFF;
                else if (mode < 5) rd = r_exp[c];
                else if (mode < 8) rd = r_exp[c] ^ (8'h01 << ($urandom % 8));
            end
            e = (rb1 && r_ev[c]) ? weight(rd ^ r_exp[c]) : 0;
            if (rv) begin
                if (rs) begin
                    r_exp[c] = r_acc[c]; r_ev[c] = r_st[c]; r_st[c] = 1; r_acc[c] = rd; r_idx[c] = 1;
                end else begin
                    r_acc[c] ^= rd;
                    if (r_idx[c] < IMAX) r_idx[c]++;
                end
            end
            rx_valid[c] = rv; rx_sof[c] = rs; rx_data[c*8 +: 8] = rd;

            cl = clr_on_b1[c] ? rb1 : (!no_rand_clr && ($urandom % 32 == 0));
            ci = !no_rand_clr && ($urandom % 32 == 0);
            clr_cnt[c] = cl; clr_irq[c] = ci;
            base = cl ? 0 : m_cnt[c];
            sum = base + e;
            if (sum > CMAX) begin
                m_cnt[c] = CMAX; m_ovf[c] = 1;
            end else begin
                m_cnt[c] = sum;
                if (cl) m_ovf[c] = 0;
            end
            m_irq[c] = (e != 0) || (m_irq[c] && !ci);
        end
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog expired, got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 0;
        tx_in_data = '0; tx_in_sof = '0; tx_in_valid = '0;
        rx_data = '0; rx_sof = '0; rx_valid = '0; clr_cnt = '0; clr_irq = '0;
        model_reset();
        no_rand_clr = 1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        for (int c = 0; c < NCH; c++) begin
            chk(err_cnt[c*CW +: CW] == 0, "R10", "reset cnt", c, err_cnt[c*CW +: CW], 0);
            chk(err_ovf[c] == 0 && irq[c] == 0, "R10", "reset flags", c, {err_ovf[c], irq[c]}, 0);
            chk(tx_out_valid[c] == 0, "R10", "reset tx valid", c, tx_out_valid[c], 0);
        end
        rst_n = 1;

        // R3: first frame not checked even with a fully inverted slot
        flip_all[0] = 1;
        while (!(r_st[0] && r_idx[0] > SLOT)) step();
        chk(err_cnt[CW-1:0] == 0, "R3", "first frame cnt", 0, err_cnt[CW-1:0], 0);
        flip_all[0] = 0;

        // R1 R2 R4 R7: random traffic with random clears colliding with errors (R6)
        no_rand_clr = 0;
        repeat (3000) step();

        // R8 R5: only channel 2 runs, slot fully inverted, until saturated
        no_rand_clr = 1;
        for (int c = 0; c < NCH; c++) idle[c] = (c != 2);
        flip_all[2] = 1;
        begin
            int keep0;
            keep0 = int'(err_cnt[CW-1:0]);
            repeat (600) step();
            chk(err_cnt[2*CW +: CW] == CMAX, "R5", "saturated cnt", 2, err_cnt[2*CW +: CW], CMAX);
            chk(err_ovf[2] == 1, "R5", "overflow set", 2, err_ovf[2], 1);
            chk(int'(err_cnt[CW-1:0]) == keep0, "R8", "idle channel cnt", 0, err_cnt[CW-1:0], keep0);
        end

        // R6: clear on every slot byte while the slot mismatches in all bits
        clr_on_b1[2] = 1;
        repeat (200) step();
        chk(err_ovf[2] == 0, "R6", "overflow after clear", 2, err_ovf[2], 0);
        chk(err_cnt[2*CW +: CW] == 8, "R6", "cnt after clear+err", 2, err_cnt[2*CW +: CW], 8);

        for (int c = 0; c < NCH; c++) begin
            idle[c] = 0; flip_all[c] = 0; clr_on_b1[c] = 0;
        end
        no_rand_clr = 0;
        repeat (1500) step();

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule